// File: doc/BRIEF.md
# Timer trigger output selector

This block picks what a general-purpose timer presents on its two trigger outputs. These outputs feed other timers or converters. The main output can carry one of four things: the software update-generation bit, the counter-run signal, the update event, or the channel-1 compare-flag strobe. It can also carry one of the first four compare reference levels. The auxiliary output offers the same choices. It adds two more reference levels, and a set of pulse modes built from edges of the channel 4, 5 and 6 references.

The counter, the compare channels and the register bus all sit outside the block. Their signals arrive on plain input ports. Each output has its own 4-bit mode port. An edge detector keeps a registered copy of every reference. It compares each reference with that copy to find rising and falling edges. Both outputs are registered, so every result shows up exactly one clock after the inputs that produced it.

Top module: `trig_out_sel`

## Requirements
- R1: While `rst_n` is low, both `trg_main` and `trg_aux` are 0.
- R2: On either output, mode 0 gives `sw_ug`, mode 1 gives `cnt_en` and mode 2 gives `upd_evt`, each one clock after it is sampled.
- R3: On either output, mode 3 gives `cc1_set`, so each one-cycle flag strobe becomes a one-cycle output pulse one clock later.
- R4: On either output, modes 4, 5, 6 and 7 pass `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]` through, delayed by one clock.
- R5: On the auxiliary output, modes 8 and 9 pass `oc_ref[4]` and `oc_ref[5]` through, delayed by one clock. On the main output, every mode from 8 to 15 holds the output at 0.
- R6: On the auxiliary output, mode 10 gives a one-cycle pulse for every rising or falling edge of `oc_ref[3]`, and mode 11 does the same for `oc_ref[5]`. The pulse is high in the cycle after the first sample that differs from the one before it.
- R7: On the auxiliary output, four combined modes OR two edge terms. Mode 12 is the rise of `oc_ref[3]` or the rise of `oc_ref[5]`. Mode 13 is the rise of `oc_ref[3]` or the fall of `oc_ref[5]`. Mode 14 is the rise of `oc_ref[4]` or the rise of `oc_ref[5]`. Mode 15 is the rise of `oc_ref[4]` or the fall of `oc_ref[5]`.
- R8: Two qualifying edges in the same sample give a single one-cycle pulse. A reference held at a steady level gives no further pulses.
- R9: The registered copies of the references reset to parameter `REF_INIT`, which defaults to all zeros. With the default, a reference that is already high at the first sample after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_ug | input | 1 | Software update-generation bit |
| cnt_en | input | 1 | Counter running |
| upd_evt | input | 1 | Update event strobe |
| cc1_set | input | 1 | Channel-1 compare flag set strobe |
| oc_ref | input | N_REF | Compare reference levels, bit 0 is channel 1 |
| sel_main | input | 4 | Mode of the main trigger output |
| sel_aux | input | 4 | Mode of the auxiliary trigger output |
| trg_main | output | 1 | Main trigger output |
| trg_aux | output | 1 | Auxiliary trigger output |

## Verification
Every result on both outputs is due on the first rising edge after the stimulus. That includes level pass-through, strobe copies and edge pulses. An edge pulse is due on the edge that first samples the changed reference, and it lasts one cycle. The bench changes inputs only on falling edges. Its behavioural model updates on the rising edge from the sampled inputs and its own record of the last references. The bench then compares both outputs on the following falling edge, so each comparison falls exactly one register stage after the stimulus.

// File: rtl/trgsel_pkg.sv
package trgsel_pkg;

   localparam int unsigned SEL_W   = 4;
   localparam int unsigned MIN_REF = 6;

   typedef enum logic [SEL_W-1:0] {
      SRC_SWUG  = 4'd0,
      SRC_CNTEN = 4'd1,
      SRC_UPD   = 4'd2,
      SRC_CC1P  = 4'd3,
      SRC_REF1  = 4'd4,
      SRC_REF2  = 4'd5,
      SRC_REF3  = 4'd6,
      SRC_REF4  = 4'd7,
      SRC_REF5  = 4'd8,
      SRC_REF6  = 4'd9,
      SRC_EDG4  = 4'd10,
      SRC_EDG6  = 4'd11,
      SRC_R4R6  = 4'd12,
      SRC_R4F6  = 4'd13,
      SRC_R5R6  = 4'd14,
      SRC_R5F6  = 4'd15
   } trg_src_e;

   typedef struct packed {
      logic sw_ug;
      logic cnt_en;
      logic upd;
      logic cc1;
   } evt_t;

endpackage

// File: rtl/trgsel_edge.sv
module trgsel_edge #(
   parameter int unsigned       N_REF = 6,
   parameter logic [N_REF-1:0]  INIT  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REF-1:0] lvl_i,
   output logic [N_REF-1:0] rise_o,
   output logic [N_REF-1:0] fall_o
);

   logic [N_REF-1:0] last_q;

   for (genvar g = 0; g < N_REF; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q[g] <= INIT[g];
         else        last_q[g] <= lvl_i[g];
      end
      assign rise_o[g] =  lvl_i[g] & ~last_q[g];
      assign fall_o[g] = ~lvl_i[g] &  last_q[g];
   end

endmodule

// File: rtl/trgsel_mux.sv
module trgsel_mux
   import trgsel_pkg::*;
#(
   parameter bit          EXT   = 1'b0,
   parameter int unsigned N_REF = 6
) (
   input  logic [SEL_W-1:0] sel_i,
   input  evt_t             ev_i,
   input  logic [N_REF-1:0] lvl_i,
   input  logic [N_REF-1:0] rise_i,
   input  logic [N_REF-1:0] fall_i,
   output logic             out_o
);

   localparam int unsigned IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1;
   localparam logic [IDX_W-1:0] CH4 = IDX_W'(3);
   localparam logic [IDX_W-1:0] CH5 = IDX_W'(4);
   localparam logic [IDX_W-1:0] CH6 = IDX_W'(5);

   logic             ext_ok;
   logic             lvl_val;
   logic             use_edge;
   logic [IDX_W-1:0] a_idx, b_idx;
   logic             a_any, b_on, b_fall;
   logic             edge_val;

   // Variant: the main output has no modes above 7
   if (EXT) begin : g_ext
      assign ext_ok = 1'b1;
   end else begin : g_base
      assign ext_ok = ~sel_i[SEL_W-1];
   end

   always_comb begin
      lvl_val  = 1'b0;
      use_edge = 1'b0;
      a_idx    = CH4;
      b_idx    = CH6;
      a_any    = 1'b0;
      b_on     = 1'b0;
      b_fall   = 1'b0;
      unique case (trg_src_e'(sel_i))
         SRC_SWUG:  lvl_val = ev_i.sw_ug;
         SRC_CNTEN: lvl_val = ev_i.cnt_en;
         SRC_UPD:   lvl_val = ev_i.upd;
         SRC_CC1P:  lvl_val = ev_i.cc1;
         SRC_REF1:  lvl_val = lvl_i[0];
         SRC_REF2:  lvl_val = lvl_i[1];
         SRC_REF3:  lvl_val = lvl_i[2];
         SRC_REF4:  lvl_val = lvl_i[3];
         SRC_REF5:  lvl_val = lvl_i[4];
         SRC_REF6:  lvl_val = lvl_i[5];
         SRC_EDG4:  begin use_edge = 1'b1; a_idx = CH4; a_any = 1'b1; end
         SRC_EDG6:  begin use_edge = 1'b1; a_idx = CH6; a_any = 1'b1; end
         SRC_R4R6:  begin use_edge = 1'b1; a_idx = CH4; b_on = 1'b1; end
         SRC_R4F6:  begin use_edge = 1'b1; a_idx = CH4; b_on = 1'b1; b_fall = 1'b1; end
         SRC_R5R6:  begin use_edge = 1'b1; a_idx = CH5; b_on = 1'b1; end
         SRC_R5F6:  begin use_edge = 1'b1; a_idx = CH5; b_on = 1'b1; b_fall = 1'b1; end
         default:   lvl_val = 1'b0;
      endcase
      edge_val = rise_i[a_idx]
               | (a_any & fall_i[a_idx])
               | (b_on & (b_fall ? fall_i[b_idx] : rise_i[b_idx]));
   end

   assign out_o = ext_ok & (use_edge ? edge_val : lvl_val);

endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
   import trgsel_pkg::*;
#(
   parameter int unsigned      N_REF    = 6,
   parameter logic [N_REF-1:0] REF_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_ug,
   input  logic             cnt_en,
   input  logic             upd_evt,
   input  logic             cc1_set,
   input  logic [N_REF-1:0] oc_ref,
   input  logic [3:0]       sel_main,
   input  logic [3:0]       sel_aux,
   output logic             trg_main,
   output logic             trg_aux
);

   if (N_REF < MIN_REF) begin : g_bad_ref
      $error("trig_out_sel: N_REF below the six references the modes use");
   end
   if (SEL_W != 4) begin : g_bad_sel
      $error("trig_out_sel: mode fields must be 4 bits wide");
   end

   evt_t             ev;
   logic [N_REF-1:0] rise, fall;
   logic             nxt_main, nxt_aux;

   assign ev = '{sw_ug: sw_ug, cnt_en: cnt_en, upd: upd_evt, cc1: cc1_set};

   trgsel_edge #(.N_REF(N_REF), .INIT(REF_INIT)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (oc_ref),
      .rise_o (rise),
      .fall_o (fall)
   );

   trgsel_mux #(.EXT(1'b0), .N_REF(N_REF)) i_mux_main (
      .sel_i  (sel_main),
      .ev_i   (ev),
      .lvl_i  (oc_ref),
      .rise_i (rise),
      .fall_i (fall),
      .out_o  (nxt_main)
   );

   trgsel_mux #(.EXT(1'b1), .N_REF(N_REF)) i_mux_aux (
      .sel_i  (sel_aux),
      .ev_i   (ev),
      .lvl_i  (oc_ref),
      .rise_i (rise),
      .fall_i (fall),
      .out_o  (nxt_aux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trg_main <= 1'b0;
         trg_aux  <= 1'b0;
      end else begin
         trg_main <= nxt_main;
         trg_aux  <= nxt_aux;
      end
   end

endmodule

// File: rtl/trgsel_chk.sv
module trgsel_chk #(
   parameter int unsigned N_REF = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_ug,
   input logic             cc1_set,
   input logic [N_REF-1:0] oc_ref,
   input logic [3:0]       sel_main,
   input logic [3:0]       sel_aux,
   input logic             trg_main,
   input logic             trg_aux
);

   logic [1:0] age;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end
   assign armed = (age == 2'd2);

   // R2
   swug_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_main == 4'd0) |=> (trg_main == $past(sw_ug)));

   // R3
   cc1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_aux == 4'd3) |=> (trg_aux == $past(cc1_set)));

   // R5
   main_high_modes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_main[3] |=> !trg_main);

   // R4
   aux_ref2_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_aux == 4'd5) |=> (trg_aux == $past(oc_ref[1])));

   // R6
   aux_edge6_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sel_aux == 4'd11) |=>
         (trg_aux == ($past(oc_ref[5]) ^ $past(oc_ref[5], 2))));

   // R7
   aux_r4f6_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sel_aux == 4'd13) |=>
         (trg_aux == (($past(oc_ref[3]) && !$past(oc_ref[3], 2)) ||
                      (!$past(oc_ref[5]) && $past(oc_ref[5], 2)))));

endmodule

bind trig_out_sel trgsel_chk #(.N_REF(N_REF)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sw_ug    (sw_ug),
   .cc1_set  (cc1_set),
   .oc_ref   (oc_ref),
   .sel_main (sel_main),
   .sel_aux  (sel_aux),
   .trg_main (trg_main),
   .trg_aux  (trg_aux)
);

// File: tb/test_trig_out_sel.sv
`timescale 1ns/1ps
module test_trig_out_sel;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sw_ug, cnt_en, upd_evt, cc1_set;
   logic [5:0] oc_ref;
   logic [3:0] sel_main, sel_aux;
   logic       trg_main, trg_aux;

   int  n_cmp  = 0;
   int  n_bad  = 0;
   bit  cmp_on = 1'b0;
   bit  done   = 1'b0;
   string phase_tag = "";

   bit       exp_main = 1'b0, exp_aux = 1'b0;
   bit [5:0] prev_ref = '0;

   always #2 clk = ~clk;

   trig_out_sel i_trig_out_sel (
      .clk(clk), .rst_n(rst_n), .sw_ug(sw_ug), .cnt_en(cnt_en),
      .upd_evt(upd_evt), .cc1_set(cc1_set), .oc_ref(oc_ref),
      .sel_main(sel_main), .sel_aux(sel_aux),
      .trg_main(trg_main), .trg_aux(trg_aux)
   );

   function automatic bit model(int m, bit ext, bit sw, bit cn, bit up, bit cc,
                                bit [5:0] r, bit [5:0] p);
      bit [5:0] ri = r & ~p;
      bit [5:0] fa = ~r & p;
      if (!ext && m >= 8) return 1'b0;
      if (m == 0) return sw;
      if (m == 1) return cn;
      if (m == 2) return up;
      if (m == 3) return cc;
      if (m <= 9) return r[m-4];
      if (m == 10) return ri[3] | fa[3];
      if (m == 11) return ri[5] | fa[5];
      if (m == 12) return ri[3] | ri[5];
      if (m == 13) return ri[3] | fa[5];
      if (m == 14) return ri[4] | ri[5];
      return ri[4] | fa[5];
   endfunction

   function automatic string req_of(int m, bit ext);
      if (m <= 2) return "R2";
      if (m == 3) return "R3";
      if (m <= 7) return "R4";
      if (!ext || m <= 9) return "R5";
      if (m <= 11) return "R6";
      return "R7";
   endfunction

   // reference model: advances on the rising edge from sampled inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_main = 1'b0;
         exp_aux  = 1'b0;
         prev_ref = '0;
      end else begin
         exp_main = model(int'(sel_main), 1'b0, sw_ug, cnt_en, upd_evt, cc1_set, oc_ref, prev_ref);
         exp_aux  = model(int'(sel_aux),  1'b1, sw_ug, cnt_en, upd_evt, cc1_set, oc_ref, prev_ref);
         prev_ref = oc_ref;
      end
   end

   task automatic compare_now();
      string tm, ta;
      if (!cmp_on) return;
      if (!rst_n) begin tm = "R1"; ta = "R1"; end
      else if (phase_tag != "") begin tm = phase_tag; ta = phase_tag; end
      else begin tm = req_of(int'(sel_main), 1'b0); ta = req_of(int'(sel_aux), 1'b1); end
      n_cmp += 2;
      if (trg_main !== exp_main) begin
         n_bad++;
         $display("FAIL %s main mode %0d: got %b expected %b at %0t", tm, sel_main, trg_main, exp_main, $time);
      end
      if (trg_aux !== exp_aux) begin
         n_bad++;
         $display("FAIL %s aux mode %0d: got %b expected %b at %0t", ta, sel_aux, trg_aux, exp_aux, $time);
      end
   endtask

   // one cycle: compare the previous result, then apply new inputs
   task automatic step(bit r, bit sw, bit cn, bit up, bit cc, bit [5:0] rf);
      @(negedge clk);
      compare_now();
      rst_n = r; sw_ug = sw; cnt_en = cn; upd_evt = up; cc1_set = cc; oc_ref = rf;
   endtask

   task automatic rand_cycles(int n);
      for (int i = 0; i < n; i++) begin
         bit [5:0] flip = 6'($urandom) & 6'($urandom);
         step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), oc_ref ^ flip);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      rst_n = 1'b0; sw_ug = 0; cnt_en = 0; upd_evt = 0; cc1_set = 0;
      oc_ref = '0; sel_main = '0; sel_aux = '0;
      repeat (2) @(posedge clk);
      cmp_on = 1'b1;
      // R1: outputs quiet while reset is held, even with busy inputs
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'h3F);
      step(1'b1, 0, 0, 0, 0, '0);
      step(1'b1, 0, 0, 0, 0, '0);

      // R2..R7: every mode on both outputs with random activity
      for (int m = 0; m < 16; m++) begin
         sel_main = 4'(m);
         sel_aux  = 4'(15 - m);
         rand_cycles(30);
         sel_aux  = 4'(m);
         rand_cycles(30);
      end

      // R8: coincident rises on channels 4 and 6 merge, held levels stay quiet
      phase_tag = "R8";
      sel_main = 4'd12; sel_aux = 4'd12;
      step(1'b1, 0, 0, 0, 0, 6'h00);
      step(1'b1, 0, 0, 0, 0, 6'h28);
      for (int i = 0; i < 4; i++) step(1'b1, 0, 0, 0, 0, 6'h28);
      sel_aux = 4'd13;
      step(1'b1, 0, 0, 0, 0, 6'h20);
      step(1'b1, 0, 0, 0, 0, 6'h08);
      for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 0, 0, 6'h08);

      // R9: reference high across reset counts as a rising edge afterwards
      phase_tag = "";
      sel_aux = 4'd10;
      for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 0, 0, 6'h08);
      phase_tag = "R9";
      for (int i = 0; i < 4; i++) step(1'b1, 0, 0, 0, 0, 6'h08);

      phase_tag = "";
      rand_cycles(20);
      @(negedge clk);
      compare_now();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): got hang expected completion");
         summary();
         $finish;
      end
   end

endmodule